// File: doc/BRIEF.md
# Jump-and-Link Delay-Slot Program Counter Sequencer

This block walks a program counter through a stream of 32-bit instruction words, one word per cycle on which the valid strobe is high. It decodes one instruction class: the region-based jump-and-link. When one is accepted, the block emits a link write to register 31 in the same cycle. The redirect waits for the next accepted word, which is the delay slot. That slot instruction issues from the sequential address. The PC then moves to the jump target. The upper bits of the target are taken from the delay slot's own address, so a jump placed in the last word of a region lands in the following region.

If the word in the delay slot is itself a control transfer, the block raises a reserved-instruction exception flag for that cycle. It also drops the pending redirect. A pipeline front end uses the block as its fetch-address generator. It drives `instrWord`/`instrValid` for the address shown on `pcCur` and reads `pcNext` as the PC that takes effect at the clock edge.

Top module: `jal_slot_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC loads `resetVector` and any pending redirect is cleared. After reset, with no valid word, `linkWrEn` and `riExcept` are 0.
- R2: On a valid cycle with no pending redirect and a word that is not a jump-and-link, `pcNext` is `pcCur + 4`, and `pcCur` takes that value at the edge.
- R3: On a cycle with `instrValid` low, `pcNext` equals `pcCur`. The PC and any pending redirect are held, and no link write or exception is signalled.
- R4: A valid word with bits 31:26 equal to 6'b000011, accepted outside a delay slot, is a jump-and-link. In that cycle `linkWrEn` is 1, `linkWrAddr` is 31 and `linkWrData` is `pcCur + 8`.
- R5: The word after a jump-and-link issues from the jump's address plus 4. The cycle of the jump shows `pcNext = pcCur + 4`.
- R6: In the delay-slot cycle, `pcNext` is the target: bits 31:28 from the delay-slot address, bits 27:2 from instruction bits 25:0, and bits 1:0 zero. The following word issues from that target.
- R7: A jump-and-link at the last word of a 256 MB region (address ending 0xFFFFFFC) takes its upper four target bits from the next region.
- R8: A delay-slot word that is a control transfer raises `riExcept` in that cycle, with `pcNext = pcCur + 4` and no link write. No redirect follows. Control transfers are primary opcodes 000010, 000011, 000100 to 000111, and opcode 000000 with function bits 5:0 equal to 001000 or 001001.
- R9: A delay-slot word with opcode 000000 and any other function code (for example 100000) is not a control transfer. It raises no exception, and the redirect still happens.
- R10: A jump-and-link word presented with `instrValid` low produces no link write and arms no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| resetVector | input | 32 | PC loaded during reset |
| instrValid | input | 1 | Instruction word valid this cycle |
| instrWord | input | 32 | Instruction at address `pcCur` |
| pcCur | output | 32 | Address of the instruction being presented |
| pcNext | output | 32 | PC value taken at the next rising edge |
| linkWrEn | output | 1 | Register write strobe for the link value |
| linkWrAddr | output | 5 | Register index of the link write (31) |
| linkWrData | output | 32 | Link value (`pcCur + 8`) |
| riExcept | output | 1 | Reserved-instruction exception: control transfer in a delay slot |

## Verification
Straight-line streams of non-jump words check the plain +4 stepping. Bubbles placed between a jump and its delay slot show that the pending redirect survives idle cycles. Each class of control transfer is placed in the delay slot: primary-opcode jumps and branches, register jumps, and a second jump-and-link. This separates a correct decode from one that misses a class or fires on a neighbouring function code. A jump placed at a region's last word shows whether the target's upper bits come from the jump or from its slot. A jump word presented without its valid strobe shows whether the strobe gates the link write.

// File: rtl/jlseq_pkg.sv
package jlseq_pkg;

  localparam int INSTR_W = 32;
  localparam int OPC_LSB = 26;
  localparam int INDEX_W = 26;

  localparam logic [5:0] OPC_SPECIAL = 6'b000000;
  localparam logic [5:0] OPC_J       = 6'b000010;
  localparam logic [5:0] OPC_JAL     = 6'b000011;
  localparam logic [5:0] OPC_BR_LO   = 6'b000100;
  localparam logic [5:0] OPC_BR_HI   = 6'b000111;
  localparam logic [5:0] FN_JR       = 6'b001000;
  localparam logic [5:0] FN_JALR     = 6'b001001;

  // Strobes from control to datapath
  typedef struct packed {
    logic advance;        // accept a word, move the PC
    logic takeTarget;     // delay slot clean: PC goes to the stored target
    logic captureTarget;  // jump-and-link accepted: store its target
  } seqStrobe_t;

  function automatic logic isJal(input logic [INSTR_W-1:0] w);
    return w[INSTR_W-1:OPC_LSB] == OPC_JAL;
  endfunction

  function automatic logic isCti(input logic [INSTR_W-1:0] w);
    logic [5:0] opc;
    logic [5:0] fn;
    opc = w[INSTR_W-1:OPC_LSB];
    fn  = w[5:0];
    return (opc == OPC_J) || (opc == OPC_JAL) ||
           ((opc >= OPC_BR_LO) && (opc <= OPC_BR_HI)) ||
           ((opc == OPC_SPECIAL) && ((fn == FN_JR) || (fn == FN_JALR)));
  endfunction

endpackage

// File: rtl/jal_slot_ctrl.sv
module jal_slot_ctrl
  import jlseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  output seqStrobe_t         str,
  output logic               linkWrEn,
  output logic               riExcept
);

  logic pending;     // current word sits in a delay slot
  logic wordIsJal;
  logic wordIsCti;

  assign wordIsJal = isJal(instrWord);
  assign wordIsCti = isCti(instrWord);

  always_comb begin
    str.advance       = instrValid;
    str.takeTarget    = instrValid && pending && !wordIsCti;
    str.captureTarget = instrValid && !pending && wordIsJal;
    linkWrEn          = str.captureTarget;
    riExcept          = instrValid && pending && wordIsCti;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pending <= 1'b0;
    else if (instrValid)
      pending <= str.captureTarget;
  end

  // R4: an accepted jump arms the delay slot
  p_link_arms_r4: assert property (@(posedge clk) disable iff (!rst_n)
    linkWrEn |=> pending);

  // R5: the slot word consumes the pending state
  p_slot_consumed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (instrValid && pending) |=> !pending);

  // R3: bubbles keep the pending state
  p_bubble_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !instrValid |=> $stable(pending));

  // R8: exception and link write never coincide
  p_except_no_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(riExcept && linkWrEn));

endmodule

// File: rtl/jal_slot_dp.sv
module jal_slot_dp
  import jlseq_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PC_W-1:0]    resetVector,
  input  logic [INDEX_W-1:0] instrIndex,
  input  seqStrobe_t         str,
  output logic [PC_W-1:0]    pcCur,
  output logic [PC_W-1:0]    pcNext,
  output logic [PC_W-1:0]    linkWrData
);

  localparam int REGION_LSB = INDEX_W + 2;

  logic [PC_W-1:0] pcQ;
  logic [PC_W-1:0] targetQ;
  logic [PC_W-1:0] slotAddr;
  logic [PC_W-1:0] targetD;

  assign slotAddr   = pcQ + PC_W'(4);
  assign linkWrData = pcQ + PC_W'(8);
  assign targetD    = {slotAddr[PC_W-1:REGION_LSB], instrIndex, 2'b00};

  always_comb begin
    if (!str.advance)
      pcNext = pcQ;
    else if (str.takeTarget)
      pcNext = targetQ;
    else
      pcNext = slotAddr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcQ     <= resetVector;
      targetQ <= '0;
    end else begin
      pcQ <= pcNext;
      if (str.captureTarget)
        targetQ <= targetD;
    end
  end

  assign pcCur = pcQ;

  // R2: sequential step on ordinary accepted words
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (str.advance && !str.takeTarget) |=> pcCur == $past(pcCur) + PC_W'(4));

  // R3: idle cycles hold the PC
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !str.advance |=> $stable(pcCur));

  // R6: a clean delay slot lands on the stored target, word aligned
  p_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (str.advance && str.takeTarget) |=> (pcCur == $past(targetQ)) && (pcCur[1:0] == 2'b00));

endmodule

// File: rtl/jal_slot_seq.sv
module jal_slot_seq
  import jlseq_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int RA_W     = 5,
  parameter int LINK_REG = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] resetVector,
  input  logic            instrValid,
  input  logic [31:0]     instrWord,
  output logic [PC_W-1:0] pcCur,
  output logic [PC_W-1:0] pcNext,
  output logic            linkWrEn,
  output logic [RA_W-1:0] linkWrAddr,
  output logic [PC_W-1:0] linkWrData,
  output logic            riExcept
);

  localparam logic [RA_W-1:0] LINK_ADDR = RA_W'(LINK_REG);

  seqStrobe_t str;

  jal_slot_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .str        (str),
    .linkWrEn   (linkWrEn),
    .riExcept   (riExcept)
  );

  jal_slot_dp #(.PC_W(PC_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .resetVector (resetVector),
    .instrIndex  (instrWord[INDEX_W-1:0]),
    .str         (str),
    .pcCur       (pcCur),
    .pcNext      (pcNext),
    .linkWrData  (linkWrData)
  );

  assign linkWrAddr = LINK_ADDR;

endmodule

// File: tb/sim_jal_slot_seq.sv
module sim_jal_slot_seq;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] resetVector;
  logic        instrValid;
  logic [31:0] instrWord;
  logic [31:0] pcCur, pcNext, linkWrData;
  logic        linkWrEn, riExcept;
  logic [4:0]  linkWrAddr;

  jal_slot_seq u0 (
    .clk(clk), .rst_n(rst_n), .resetVector(resetVector),
    .instrValid(instrValid), .instrWord(instrWord),
    .pcCur(pcCur), .pcNext(pcNext), .linkWrEn(linkWrEn),
    .linkWrAddr(linkWrAddr), .linkWrData(linkWrData), .riExcept(riExcept)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    string       req;
    logic [31:0] pc;
    logic [31:0] nxt;
    logic        lnk;
    logic [31:0] lnkData;
    logic        exc;
  } expItem_t;

  expItem_t scoreQ[$];
  int vecCount = 0;
  int missCount = 0;

  // bench-side model state
  logic [31:0] mPc;
  logic        mPend;
  logic [31:0] mTgt;

  function automatic logic benchCti(input logic [31:0] w);
    logic [5:0] o;
    o = w[31:26];
    return o == 6'd2 || o == 6'd3 || (o >= 6'd4 && o <= 6'd7) ||
           (o == 6'd0 && (w[5:0] == 6'b001000 || w[5:0] == 6'b001001));
  endfunction

  task automatic apply(input logic v, input logic [31:0] w, input string req);
    expItem_t e;
    @(negedge clk);
    instrValid = v;
    instrWord  = w;
    e.req = req; e.pc = mPc; e.lnk = 1'b0; e.lnkData = mPc + 32'd8; e.exc = 1'b0;
    if (!v) begin
      e.nxt = mPc;
    end else if (mPend) begin
      mPend = 1'b0;
      if (benchCti(w)) begin
        e.exc = 1'b1;
        e.nxt = mPc + 32'd4;
      end else begin
        e.nxt = mTgt;
      end
    end else if (w[31:26] == 6'b000011) begin
      e.lnk = 1'b1;
      mPend = 1'b1;
      mTgt  = {mPc[31:28] + 4'((mPc[27:0] == 28'hFFFFFFC) ? 1 : 0), w[25:0], 2'b00};
      e.nxt = mPc + 32'd4;
    end else begin
      e.nxt = mPc + 32'd4;
    end
    mPc = e.nxt;
    scoreQ.push_back(e);
  endtask

  task automatic doReset(input logic [31:0] vec);
    @(negedge clk);
    rst_n = 1'b0; resetVector = vec; instrValid = 1'b0; instrWord = '0;
    repeat (2) @(negedge clk);
    #(CLK_P/4);
    vecCount++;
    if (pcCur !== vec || linkWrEn !== 1'b0 || riExcept !== 1'b0) begin
      missCount++;
      $display("FAIL R1 reset: pc=%h lnk=%b exc=%b expected pc=%h lnk=0 exc=0",
               pcCur, linkWrEn, riExcept, vec);
    end
    @(negedge clk);
    rst_n = 1'b1;
    mPc = vec; mPend = 1'b0; mTgt = '0;
  endtask

  // monitor: compare each driven cycle a quarter period after the driving edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (scoreQ.size() > 0) begin
        expItem_t e;
        e = scoreQ.pop_front();
        vecCount++;
        if (pcCur !== e.pc || pcNext !== e.nxt || linkWrEn !== e.lnk ||
            riExcept !== e.exc || (e.lnk && (linkWrData !== e.lnkData || linkWrAddr !== 5'd31))) begin
          missCount++;
          $display("FAIL %s: pc=%h nxt=%h lnk=%b data=%h addr=%0d exc=%b expected pc=%h nxt=%h lnk=%b data=%h addr=31 exc=%b",
                   e.req, pcCur, pcNext, linkWrEn, linkWrData, linkWrAddr, riExcept,
                   e.pc, e.nxt, e.lnk, e.lnkData, e.exc);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 5000);
    missCount++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  localparam logic [31:0] NOP  = 32'h0000_0000;
  localparam logic [31:0] ADD  = 32'h0109_5020;   // opcode 0, function 100000
  localparam logic [31:0] ADDI = 32'h2108_0001;

  function automatic logic [31:0] jal(input logic [25:0] idx);
    return {6'b000011, idx};
  endfunction

  initial begin
    rst_n = 1'b0; resetVector = 32'h0040_0000; instrValid = 1'b0; instrWord = '0;
    mPc = '0; mPend = 1'b0; mTgt = '0;

    doReset(32'h0040_0000);                 // R1
    apply(1'b1, NOP,  "R2");
    apply(1'b1, ADDI, "R2");
    apply(1'b0, ADDI, "R3");
    apply(1'b1, jal(26'h0123456), "R4");    // jump at 0x00400008
    apply(1'b0, NOP,  "R3");                // bubble keeps pending
    apply(1'b0, NOP,  "R3");
    apply(1'b1, ADD,  "R5");                // slot at 0x0040000C
    apply(1'b1, NOP,  "R6");                // at target
    apply(1'b1, jal(26'h3FFFFFF), "R4");
    apply(1'b1, NOP,  "R6");
    apply(1'b1, NOP,  "R6");

    // R8: each class of control transfer in the slot
    apply(1'b1, jal(26'h0000100), "R4");
    apply(1'b1, 32'h03E0_0008, "R8");       // JR
    apply(1'b1, NOP, "R8");                 // no redirect afterwards
    apply(1'b1, jal(26'h0000200), "R4");
    apply(1'b1, 32'h0120_F809, "R8");       // JALR
    apply(1'b1, jal(26'h0000300), "R4");
    apply(1'b1, 32'h1000_0004, "R8");       // BEQ
    apply(1'b1, jal(26'h0000400), "R4");
    apply(1'b1, 32'h1C20_0002, "R8");       // BGTZ
    apply(1'b1, jal(26'h0000500), "R4");
    apply(1'b1, 32'h0800_0010, "R8");       // J
    apply(1'b1, jal(26'h0000600), "R4");
    apply(1'b1, jal(26'h0000700), "R8");    // JAL in slot: no link write
    apply(1'b1, NOP, "R8");

    // R9: near-miss function codes in the slot still redirect
    apply(1'b1, jal(26'h0000800), "R4");
    apply(1'b1, ADD, "R9");
    apply(1'b1, NOP, "R9");
    apply(1'b1, jal(26'h0000900), "R4");
    apply(1'b1, 32'h0000_000A, "R9");       // function 001010
    apply(1'b1, NOP, "R9");

    // R10: jump word without valid
    apply(1'b0, jal(26'h0000A00), "R10");
    apply(1'b1, NOP, "R10");
    apply(1'b1, NOP, "R10");

    // R7: region boundary
    doReset(32'h0FFF_FFFC);                 // R1
    apply(1'b1, jal(26'h0000010), "R7");
    apply(1'b1, NOP, "R7");                 // slot at 0x10000000
    apply(1'b1, NOP, "R7");                 // at 0x10000040

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule